// File: doc/BRIEF.md
# Character Display Instruction Executor

This block is the command and data side of a character display controller. A host drives bus cycles on an 8-bit data bus, each qualified by a register-select bit `rs` and a read/write bit `rw`. With `rs` low, a write is a command and a read returns status. With `rs` high, the cycle reads or writes one byte of either the display RAM or the character-generator RAM. The byte is taken at the address counter, and the counter then steps up or down.

Each accepted command or data access starts a busy period, counted in pulses of an internal `tick` strobe. Clear and return-home use a long period. Every other access uses a short one. The host polls the busy bit through a status read, and status reads are always served. While busy, any other access is dropped and a sticky error output is raised. The display, cursor, blink, entry-mode and interface-mode settings are held as output bits for the drive logic that follows this block.

Top module: `chrdisp_exec`

## Requirements
- R1: After reset: `ac`=0, `busy`=0, `shift_ofs`=0, `cg_sel`=0, `inc_dir`=1, `shift_en`=0, `disp_on`=`cursor_on`=`blink_on`=0, `mode_8bit`=1, `two_line`=0, `big_font`=0, `err_sticky`=0, and every display RAM byte is 0x20.
- R2: A command write (`rs`=0, `rw`=0) is decoded by its highest set bit: 0x01 clear; 0x02/0x03 home; 0000_01ab entry mode (a=increment, b=shift); 0000_1dcb display control; 0001_sr-- shift (s=1 display, r=1 right); 001m_nf-- function; 01aa_aaaa character RAM address; 1aaa_aaaa display RAM address. 0x00 has no effect and starts no busy period.
- R3: Clear fills every display RAM byte with 0x20, sets `ac`=0, `shift_ofs`=0 and `cg_sel`=0.
- R4: Home sets `ac`=0, `shift_ofs`=0 and `cg_sel`=0, and leaves RAM contents unchanged.
- R5: A status read (`rs`=0, `rw`=1) puts {busy, ac} on `rdata` in the cycle after it and never starts a busy period.
- R6: A data write stores `wdata` at `ac` in the RAM that `cg_sel` selects. A data read puts that byte on `rdata` in the cycle after it.
- R7: After each data access, `ac` steps by +1 when `inc_dir`=1 and by -1 otherwise, wrapping within the selected RAM's depth. A display RAM write with `shift_en`=1 also steps `shift_ofs` in the same direction, modulo DD_DEPTH.
- R8: Display control loads `disp_on`, `cursor_on` and `blink_on` from bits 2, 1 and 0. Function set loads `mode_8bit`, `two_line` and `big_font` from bits 4, 3 and 2.
- R9: The shift command with bit 3 = 0 steps `ac` and with bit 3 = 1 steps `shift_ofs`. Bit 2 = 1 means +1 and bit 2 = 0 means -1, both with wrap.
- R10: A character RAM address command sets `cg_sel`=1 and `ac` to its low 6 bits. A display RAM address command sets `cg_sel`=0 and `ac` to its 7-bit value, with DD_DEPTH subtracted when the value is DD_DEPTH or more.
- R11: `busy` rises in the cycle after an accepted access. It stays high for LONG_TICKS tick pulses after clear or home, and for SHORT_TICKS tick pulses after any other command or data access. Without tick pulses, `busy` holds.
- R12: Any access other than a status read that arrives while `busy` is high has no effect on state or RAM, and it sets `err_sticky`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Internal time-base strobe for busy counting |
| cyc_valid | input | 1 | Bus cycle present this clock |
| rs | input | 1 | 0 = command/status, 1 = RAM data |
| rw | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read result, valid the cycle after a read |
| busy | output | 1 | Execution in progress |
| ac | output | 7 | Address counter |
| shift_ofs | output | 7 | Display shift offset |
| cg_sel | output | 1 | 1 = data accesses target character RAM |
| inc_dir | output | 1 | Address step direction, 1 = up |
| shift_en | output | 1 | Shift display on data writes |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Cursor blink enable |
| mode_8bit | output | 1 | Stored interface width bit |
| two_line | output | 1 | Stored line count bit |
| big_font | output | 1 | Stored font size bit |
| err_sticky | output | 1 | Access was dropped while busy |

## Verification
The assertions check several rules on every cycle. A dropped access leaves `ac` untouched and raises the sticky error, and that error never falls. A status read returns the busy bit and counter from the cycle before and never starts a busy period. The counter always stays inside the selected RAM. `busy` cannot rise without an accepted access, and it cannot fall without a tick. The bench scenarios cover what needs a history of accesses: RAM contents written and then read back, wrap at both ends of both RAMs, the clear fill, home leaving data in place, and the exact busy lengths counted in ticks.

// File: rtl/chrdisp_pkg.sv
package chrdisp_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP,
    OP_SHIFT, OP_FUNC, OP_CGADR, OP_DDADR
  } op_e;

  // Leading-one decode of a command byte.
  function automatic op_e lead_op(input logic [7:0] b);
    op_e o;
    casez (b)
      8'b1???_????: o = OP_DDADR;
      8'b01??_????: o = OP_CGADR;
      8'b001?_????: o = OP_FUNC;
      8'b0001_????: o = OP_SHIFT;
      8'b0000_1???: o = OP_DISP;
      8'b0000_01??: o = OP_ENTRY;
      8'b0000_001?: o = OP_HOME;
      8'b0000_0001: o = OP_CLEAR;
      default:      o = OP_NONE;
    endcase
    return o;
  endfunction

  // One step up or down inside [0, lim-1] with wrap.
  function automatic logic [6:0] step_wrap(input logic [6:0] a, input logic up,
                                           input logic [7:0] lim);
    logic [7:0] ax;
    ax = {1'b0, a};
    if (up) return (ax == lim - 8'd1) ? 7'd0 : 7'(ax + 8'd1);
    else    return (a == 7'd0) ? 7'(lim - 8'd1) : 7'(ax - 8'd1);
  endfunction

  // Reduce a 7-bit display address into [0, lim-1].
  function automatic logic [6:0] fold_addr(input logic [6:0] a, input logic [7:0] lim);
    return ({1'b0, a} >= lim) ? 7'({1'b0, a} - lim) : a;
  endfunction

endpackage

// File: rtl/chrdisp_decode.sv
module chrdisp_decode
  import chrdisp_pkg::*;
(
  input  logic [7:0] cmd,
  output op_e        op
);
  assign op = lead_op(cmd);
endmodule

// File: rtl/chrdisp_busy.sv
module chrdisp_busy #(
  parameter int LONG_TICKS  = 410,
  parameter int SHORT_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic long_sel,
  output logic busy
);
  localparam int CW = $clog2(LONG_TICKS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (start)               cnt <= long_sel ? CW'(LONG_TICKS) : CW'(SHORT_TICKS);
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/chrdisp_exec.sv
module chrdisp_exec
  import chrdisp_pkg::*;
#(
  parameter int DD_DEPTH    = 80,
  parameter int CG_DEPTH    = 64,
  parameter int LONG_TICKS  = 410,
  parameter int SHORT_TICKS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cyc_valid,
  input  logic       rs,
  input  logic       rw,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       busy,
  output logic [6:0] ac,
  output logic [6:0] shift_ofs,
  output logic       cg_sel,
  output logic       inc_dir,
  output logic       shift_en,
  output logic       disp_on,
  output logic       cursor_on,
  output logic       blink_on,
  output logic       mode_8bit,
  output logic       two_line,
  output logic       big_font,
  output logic       err_sticky
);
  localparam int         CG_AW  = $clog2(CG_DEPTH);
  localparam logic [7:0] DD_LIM = 8'(DD_DEPTH);
  localparam logic [7:0] CG_LIM = 8'(CG_DEPTH);

  logic [7:0] dd_mem [DD_DEPTH];
  logic [7:0] cg_mem [CG_DEPTH];

  // Named internal events (observed by the checker).
  op_e  op_w;
  logic stat_rd_w, blocked_w, cmd_go_w, data_go_w, long_w;
  logic [7:0] sel_lim_w, ram_byte_w;

  chrdisp_decode u_dec (.cmd(wdata), .op(op_w));

  assign stat_rd_w = cyc_valid && !rs && rw;
  assign blocked_w = cyc_valid && busy && !stat_rd_w;
  assign cmd_go_w  = cyc_valid && !busy && !rs && !rw && (op_w != OP_NONE);
  assign data_go_w = cyc_valid && !busy && rs;
  assign long_w    = (op_w == OP_CLEAR) || (op_w == OP_HOME);
  assign sel_lim_w = cg_sel ? CG_LIM : DD_LIM;
  assign ram_byte_w = cg_sel ? cg_mem[ac[CG_AW-1:0]] : dd_mem[ac];

  chrdisp_busy #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_busy (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .start(cmd_go_w || data_go_w), .long_sel(cmd_go_w && long_w), .busy(busy)
  );

  // Display RAM: single-cycle fill on clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DD_DEPTH; i++) dd_mem[i] <= 8'h20;
    end else if (cmd_go_w && op_w == OP_CLEAR) begin
      for (int i = 0; i < DD_DEPTH; i++) dd_mem[i] <= 8'h20;
    end else if (data_go_w && !rw && !cg_sel) begin
      dd_mem[ac] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CG_DEPTH; i++) cg_mem[i] <= 8'h00;
    end else if (data_go_w && !rw && cg_sel) begin
      cg_mem[ac[CG_AW-1:0]] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= 8'h00;
    else if (stat_rd_w) rdata <= {busy, ac};
    else if (data_go_w && rw) rdata <= ram_byte_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_sticky <= 1'b0;
    else if (blocked_w) err_sticky <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac <= '0; shift_ofs <= '0; cg_sel <= 1'b0;
      inc_dir <= 1'b1; shift_en <= 1'b0;
      disp_on <= 1'b0; cursor_on <= 1'b0; blink_on <= 1'b0;
      mode_8bit <= 1'b1; two_line <= 1'b0; big_font <= 1'b0;
    end else if (data_go_w) begin
      ac <= step_wrap(ac, inc_dir, sel_lim_w);
      if (!rw && !cg_sel && shift_en) shift_ofs <= step_wrap(shift_ofs, inc_dir, DD_LIM);
    end else if (cmd_go_w) begin
      unique case (op_w)
        OP_CLEAR, OP_HOME: begin ac <= '0; shift_ofs <= '0; cg_sel <= 1'b0; end
        OP_ENTRY: begin inc_dir <= wdata[1]; shift_en <= wdata[0]; end
        OP_DISP:  begin disp_on <= wdata[2]; cursor_on <= wdata[1]; blink_on <= wdata[0]; end
        OP_SHIFT: begin
          if (wdata[3]) shift_ofs <= step_wrap(shift_ofs, wdata[2], DD_LIM);
          else          ac        <= step_wrap(ac, wdata[2], sel_lim_w);
        end
        OP_FUNC:  begin mode_8bit <= wdata[4]; two_line <= wdata[3]; big_font <= wdata[2]; end
        OP_CGADR: begin ac <= 7'(wdata[CG_AW-1:0]); cg_sel <= 1'b1; end
        OP_DDADR: begin ac <= fold_addr(wdata[6:0], DD_LIM); cg_sel <= 1'b0; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/chrdisp_exec_chk.sv
module chrdisp_exec_chk
  import chrdisp_pkg::*;
#(
  parameter int DD_DEPTH = 80,
  parameter int CG_DEPTH = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       cyc_valid,
  input logic       rs,
  input logic       rw,
  input logic [7:0] rdata,
  input logic       busy,
  input logic [6:0] ac,
  input logic [6:0] shift_ofs,
  input logic       cg_sel,
  input logic       err_sticky,
  input logic       blocked_w,
  input logic       cmd_go_w,
  input logic       data_go_w,
  input op_e        op_w
);
  a_r12_blocked_keeps_ac: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_w |=> $stable(ac));
  a_r12_blocked_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_w |=> err_sticky);
  a_r12_err_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
  a_r5_status_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !rs && rw && !busy) |=> !busy);
  a_r5_status_value: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !rs && rw) |=> rdata == {$past(busy), $past(ac)});
  a_r3_clear_result: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go_w && op_w == OP_CLEAR) |=> (ac == 7'd0 && shift_ofs == 7'd0 && busy && !cg_sel));
  a_r10_ac_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cg_sel ? ({1'b0, ac} < 8'(CG_DEPTH)) : ({1'b0, ac} < 8'(DD_DEPTH)));
  a_r11_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_go_w && !data_go_w) |=> !busy);
  a_r11_no_tick_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> busy);
endmodule

bind chrdisp_exec chrdisp_exec_chk #(.DD_DEPTH(DD_DEPTH), .CG_DEPTH(CG_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cyc_valid(cyc_valid), .rs(rs), .rw(rw),
  .rdata(rdata), .busy(busy), .ac(ac), .shift_ofs(shift_ofs), .cg_sel(cg_sel),
  .err_sticky(err_sticky), .blocked_w(blocked_w), .cmd_go_w(cmd_go_w),
  .data_go_w(data_go_w), .op_w(op_w)
);

// File: tb/test_chrdisp_exec.sv
module test_chrdisp_exec;
  localparam int LONG_T = 410;
  localparam int SHORT_T = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, cyc_valid = 1'b0, rs = 1'b0, rw = 1'b0;
  logic [7:0] wdata = 8'h00, rdata;
  logic busy, cg_sel, inc_dir, shift_en, disp_on, cursor_on, blink_on;
  logic mode_8bit, two_line, big_font, err_sticky;
  logic [6:0] ac, shift_ofs;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chrdisp_exec i_chrdisp_exec (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cyc_valid(cyc_valid), .rs(rs), .rw(rw),
    .wdata(wdata), .rdata(rdata), .busy(busy), .ac(ac), .shift_ofs(shift_ofs),
    .cg_sel(cg_sel), .inc_dir(inc_dir), .shift_en(shift_en), .disp_on(disp_on),
    .cursor_on(cursor_on), .blink_on(blink_on), .mode_8bit(mode_8bit),
    .two_line(two_line), .big_font(big_font), .err_sticky(err_sticky)
  );

  // {rs, rw, data, expected ac, check rdata, expected rdata}
  localparam int NV = 27;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0,1'b0,8'h80,7'h00,1'b0,8'h00}, {1'b1,1'b0,8'h41,7'h01,1'b0,8'h00},
    {1'b1,1'b0,8'h42,7'h02,1'b0,8'h00}, {1'b0,1'b0,8'h90,7'h10,1'b0,8'h00},
    {1'b1,1'b0,8'h43,7'h11,1'b0,8'h00}, {1'b0,1'b0,8'h80,7'h00,1'b0,8'h00},
    {1'b1,1'b1,8'h00,7'h01,1'b1,8'h41}, {1'b1,1'b1,8'h00,7'h02,1'b1,8'h42},
    {1'b1,1'b1,8'h00,7'h03,1'b1,8'h20}, {1'b0,1'b0,8'h04,7'h03,1'b0,8'h00},
    {1'b0,1'b0,8'h80,7'h00,1'b0,8'h00}, {1'b1,1'b0,8'h55,7'h4F,1'b0,8'h00},
    {1'b1,1'b1,8'h00,7'h4E,1'b1,8'h20}, {1'b0,1'b0,8'h06,7'h4E,1'b0,8'h00},
    {1'b0,1'b0,8'h40,7'h00,1'b0,8'h00}, {1'b1,1'b0,8'h1F,7'h01,1'b0,8'h00},
    {1'b0,1'b0,8'h7F,7'h3F,1'b0,8'h00}, {1'b1,1'b0,8'h11,7'h00,1'b0,8'h00},
    {1'b1,1'b1,8'h00,7'h01,1'b1,8'h1F}, {1'b0,1'b0,8'hFF,7'h2F,1'b0,8'h00},
    {1'b0,1'b0,8'h14,7'h30,1'b0,8'h00}, {1'b0,1'b0,8'h10,7'h2F,1'b0,8'h00},
    {1'b0,1'b0,8'h80,7'h00,1'b0,8'h00}, {1'b1,1'b1,8'h00,7'h01,1'b1,8'h55},
    {1'b0,1'b0,8'h02,7'h00,1'b0,8'h00}, {1'b0,1'b0,8'h85,7'h05,1'b0,8'h00},
    {1'b0,1'b1,8'h00,7'h05,1'b1,8'h05}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic r_s, input logic r_w, input logic [7:0] d);
    @(negedge clk); cyc_valid = 1'b1; rs = r_s; rw = r_w; wdata = d;
    @(negedge clk); cyc_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ac", ac, 0); chk("R1 busy", busy, 0); chk("R1 inc_dir", inc_dir, 1);
    chk("R1 mode_8bit", mode_8bit, 1); chk("R1 disp_on", disp_on, 0);
    chk("R1 err", err_sticky, 0); chk("R1 shift_ofs", shift_ofs, 0);

    // Vector walk: R2 R6 R7 R9 R10 R4 R5
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][25], VEC[i][24], VEC[i][23:16]);
      if (VEC[i][8]) chk($sformatf("R6 rdata vec %0d", i), rdata, VEC[i][7:0]);
      wait_idle();
      chk($sformatf("R7 ac vec %0d", i), ac, VEC[i][15:9]);
    end

    // R8 display control and function set
    access(0, 0, 8'h0D); wait_idle();
    chk("R8 disp_on", disp_on, 1); chk("R8 cursor_on", cursor_on, 0); chk("R8 blink_on", blink_on, 1);
    access(0, 0, 8'h2C); wait_idle();
    chk("R8 mode_8bit", mode_8bit, 0); chk("R8 two_line", two_line, 1); chk("R8 big_font", big_font, 1);

    // R2 zero byte: no effect, no busy
    access(0, 0, 8'h00);
    chk("R2 nop busy", busy, 0); chk("R2 nop ac", ac, 7'h05);

    // R11 short busy length, then tick gating
    access(0, 0, 8'h0C); count_busy(n); chk("R11 short ticks", n, SHORT_T);
    access(0, 0, 8'h0C); tick = 1'b0;
    repeat (20) @(negedge clk);
    chk("R11 holds without tick", busy, 1);
    tick = 1'b1; count_busy(n); chk("R11 resumes", n, SHORT_T);

    // R9 display shift both ways, ac untouched
    access(0, 0, 8'h18); wait_idle();
    chk("R9 shift left", shift_ofs, 7'd79); chk("R9 ac kept", ac, 7'h05);
    access(0, 0, 8'h1C); wait_idle(); chk("R9 shift right", shift_ofs, 0);

    // R7 shift on write, R4 home keeps RAM
    access(0, 0, 8'h07); wait_idle();
    access(0, 0, 8'h80); wait_idle();
    access(1, 0, 8'h61); wait_idle();
    chk("R7 shift on write", shift_ofs, 1);
    access(0, 0, 8'h02); count_busy(n);
    chk("R11 home long", n, LONG_T);
    chk("R4 ac", ac, 0); chk("R4 shift_ofs", shift_ofs, 0);
    access(0, 0, 8'h06); wait_idle();
    access(1, 1, 8'h00); chk("R4 data kept", rdata, 8'h61); wait_idle();

    // R3 clear; R5 status while busy; R12 write dropped while busy
    access(0, 0, 8'h01);
    access(0, 1, 8'h00);
    chk("R5 status busy", rdata, 8'h80);
    chk("R12 status no error", err_sticky, 0);
    access(1, 0, 8'h77);
    chk("R12 err set", err_sticky, 1); chk("R12 ac kept", ac, 0);
    wait_idle();
    access(1, 1, 8'h00); chk("R3 fill addr0", rdata, 8'h20); wait_idle();
    access(0, 0, 8'hCF); wait_idle();
    access(1, 1, 8'h00); chk("R3 fill addr79", rdata, 8'h20); wait_idle();
    chk("R12 err stays", err_sticky, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule